// File: doc/BRIEF.md
# Ambiguity-Resistant Lock Sequencer for Split-Spectrum Ranging Signals

This block steps one receiver channel from power-up to a locked, unambiguous tracking condition. Once per integration period an upstream correlator stage raises a valid strobe. With that strobe it presents four results: the prompt power, an averaged power, an averaged carrier phase error magnitude, and a signed metric equal to the very-early correlator minus the very-late one. The sequencer compares these words against programmable thresholds. It then issues code-slew and carrier-step pulses while it searches, and runs an M-of-N check on a candidate peak. It selects the loop filter configuration and, in tracking, requests a code jump of half a subcarrier period when the metric shows that a side peak has been captured.

The phases are start, search, confirm, pull-in and tracking. Tracking has a second observable sub-phase while further jumps are blocked for a programmable number of periods, so that the loops can settle after a jump. All outputs are registered. Nothing changes on cycles without the valid strobe, except the single start cycle after reset.

Top module: `trk_seq_ctrl`

## Requirements
- R1: After synchronous reset `state_num` is 0, `loop_mode` is 0 and all pulse outputs are low. On the first clock edge without reset the block enters search, code 1.
- R2: In search, each valid period with `pwr` <= `thr_acq` produces a one-cycle pulse on both `slew_req` and `fstep_req`, and the block stays in search. A valid period with `pwr` > `thr_acq` moves the block to confirm, code 3, with no pulse.
- R3: Confirm counts valid periods as trials and counts those with `pwr` > `thr_acq` as hits. When the hit count reaches `m_hits` the block goes to pull-in, code 8, even if that period is also trial number `n_trials`. When `n_trials` trials pass without enough hits, the block returns to search.
- R4: Pull-in moves to tracking, code 9, on a valid period only when `avg_pwr` > `thr_trk` and `avg_perr` < `lim_perr`, both strictly.
- R5: `loop_mode` is 0 in start, search and confirm, 1 in pull-in, and 2 in tracking, including its blocked sub-phase.
- R6: In tracking, a valid period with `pwr` < `thr_acq` returns the block to search. This takes precedence over any jump. A power equal to the threshold keeps tracking.
- R7: In tracking, when jumps are not blocked, a valid period whose two's-complement `bj_metric` has an absolute value strictly greater than `thr_bj` gives a one-cycle `jump_req`. With it, `jump_back` is 1 for a negative metric and 0 for a positive one. An absolute value equal to the threshold gives no jump.
- R8: After a jump, the next `holdoff_len` valid periods in tracking cannot cause a jump, and `state_num` reads 10 while jumps are blocked.
- R9: Cycles without `meas_valid` change neither the phase nor `state_num`, and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | One-cycle strobe marking a new set of period results |
| pwr | input | PW_W | Prompt power of the period |
| avg_pwr | input | PW_W | Averaged prompt power |
| avg_perr | input | ER_W | Averaged carrier phase error magnitude |
| bj_metric | input | BJ_W | Signed very-early minus very-late metric |
| thr_acq | input | PW_W | Detection threshold for search, confirm and loss of lock |
| thr_trk | input | PW_W | Averaged power needed to leave pull-in |
| lim_perr | input | ER_W | Phase error limit to leave pull-in |
| thr_bj | input | BJ_W | Absolute metric threshold for a jump |
| m_hits | input | CNT_W | Hits needed in confirm |
| n_trials | input | CNT_W | Trial budget in confirm |
| holdoff_len | input | HOLD_W | Valid periods blocked after a jump |
| slew_req | output | 1 | Code-phase slew pulse |
| fstep_req | output | 1 | Carrier-frequency step pulse |
| loop_mode | output | 2 | Loop filter configuration: 0 off, 1 pull-in, 2 tracking |
| jump_req | output | 1 | Half-subcarrier code jump pulse |
| jump_back | output | 1 | Jump direction: 1 for a negative metric |
| state_num | output | 4 | Observable phase code: 0, 1, 3, 8, 9 or 10 |

## Verification
The bench builds the block with 8-bit power, error and metric words, 4-bit confirm counters and a 4-bit holdoff counter, and programs M=2, N=4 and a holdoff of 2. These small values make a failed confirm and a successful one each a few periods long. They also put the end of the blocking window and the most negative metric, -128, whose magnitude only fits as an unsigned word, within a short run. A later reprogramming to N=2 places the M-th hit on the last trial, to check that a pass takes priority over a fail.

// File: rtl/trk_seq_pkg.sv
package trk_seq_pkg;

  typedef enum logic [2:0] {
    PH_START = 3'd0,
    PH_SEARCH = 3'd1,
    PH_CONFIRM = 3'd2,
    PH_PULL = 3'd3,
    PH_TRACK = 3'd4
  } phase_e;

  localparam logic [3:0] CODE_START = 4'd0;
  localparam logic [3:0] CODE_SEARCH = 4'd1;
  localparam logic [3:0] CODE_CONFIRM = 4'd3;
  localparam logic [3:0] CODE_PULL = 4'd8;
  localparam logic [3:0] CODE_TRACK = 4'd9;
  localparam logic [3:0] CODE_TRACK_HOLD = 4'd10;

  localparam logic [1:0] LOOP_OFF = 2'd0;
  localparam logic [1:0] LOOP_PULL = 2'd1;
  localparam logic [1:0] LOOP_TRACK = 2'd2;

  function automatic logic [3:0] phase_code(phase_e ph, logic blocked);
    case (ph)
      PH_SEARCH: phase_code = CODE_SEARCH;
      PH_CONFIRM: phase_code = CODE_CONFIRM;
      PH_PULL: phase_code = CODE_PULL;
      PH_TRACK: phase_code = blocked ? CODE_TRACK_HOLD : CODE_TRACK;
      default: phase_code = CODE_START;
    endcase
  endfunction

  function automatic logic [1:0] loop_sel(phase_e ph);
    case (ph)
      PH_PULL: loop_sel = LOOP_PULL;
      PH_TRACK: loop_sel = LOOP_TRACK;
      default: loop_sel = LOOP_OFF;
    endcase
  endfunction

endpackage

// File: rtl/trk_mofn.sv
module trk_mofn #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             trial,
  input  logic             hit,
  input  logic [CNT_W-1:0] m_req,
  input  logic [CNT_W-1:0] n_lim,
  output logic             pass,
  output logic             fail
);
  localparam int EW = CNT_W + 1;

  logic [EW-1:0] hits_q, trials_q;
  logic [EW-1:0] hits_nx, trials_nx;

  always_comb begin
    hits_nx = hits_q + {{(EW-1){1'b0}}, hit};
    trials_nx = trials_q + {{(EW-1){1'b0}}, 1'b1};
    pass = trial && (hits_nx >= {1'b0, m_req});
    fail = trial && !pass && (trials_nx >= {1'b0, n_lim});
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hits_q <= '0;
      trials_q <= '0;
    end else if (trial) begin
      hits_q <= hits_nx;
      trials_q <= trials_nx;
    end
  end

endmodule

// File: rtl/trk_jump_gate.sv
module trk_jump_gate #(
  parameter int BJ_W = 16,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              eval,
  input  logic [BJ_W-1:0]   metric,
  input  logic [BJ_W-1:0]   thr,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              fire,
  output logic              back,
  output logic              blocked_nx
);
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic [BJ_W-1:0] mag;
  logic blocked;

  always_comb begin
    mag = metric[BJ_W-1] ? (~metric + {{(BJ_W-1){1'b0}}, 1'b1}) : metric;
    blocked = (cnt_q != '0);
    fire = eval && !blocked && (mag > thr);
    back = metric[BJ_W-1];
    if (arm) cnt_d = '0;
    else if (fire) cnt_d = hold_len;
    else if (eval && blocked) cnt_d = cnt_q - {{(HOLD_W-1){1'b0}}, 1'b1};
    else cnt_d = cnt_q;
    blocked_nx = (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

endmodule

// File: rtl/trk_seq_ctrl.sv
module trk_seq_ctrl
  import trk_seq_pkg::*;
#(
  parameter int PW_W = 16,
  parameter int ER_W = 16,
  parameter int BJ_W = 16,
  parameter int CNT_W = 6,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [PW_W-1:0]   pwr,
  input  logic [PW_W-1:0]   avg_pwr,
  input  logic [ER_W-1:0]   avg_perr,
  input  logic [BJ_W-1:0]   bj_metric,
  input  logic [PW_W-1:0]   thr_acq,
  input  logic [PW_W-1:0]   thr_trk,
  input  logic [ER_W-1:0]   lim_perr,
  input  logic [BJ_W-1:0]   thr_bj,
  input  logic [CNT_W-1:0]  m_hits,
  input  logic [CNT_W-1:0]  n_trials,
  input  logic [HOLD_W-1:0] holdoff_len,
  output logic              slew_req,
  output logic              fstep_req,
  output logic [1:0]        loop_mode,
  output logic              jump_req,
  output logic              jump_back,
  output logic [3:0]        state_num
);
  phase_e ph_q, ph_d;
  logic slew_d;
  logic conf_clear, conf_trial, conf_pass, conf_fail;
  logic j_arm, j_eval, j_fire, j_back, j_blocked_nx;
  logic above_acq, below_acq, pull_ok;

  assign above_acq = pwr > thr_acq;
  assign below_acq = pwr < thr_acq;
  assign pull_ok = (avg_pwr > thr_trk) && (avg_perr < lim_perr);

  trk_mofn #(.CNT_W(CNT_W)) confirm_i (
    .clk(clk), .rst(rst), .clear(conf_clear), .trial(conf_trial),
    .hit(above_acq), .m_req(m_hits), .n_lim(n_trials),
    .pass(conf_pass), .fail(conf_fail)
  );

  trk_jump_gate #(.BJ_W(BJ_W), .HOLD_W(HOLD_W)) jump_i (
    .clk(clk), .rst(rst), .arm(j_arm), .eval(j_eval), .metric(bj_metric),
    .thr(thr_bj), .hold_len(holdoff_len), .fire(j_fire), .back(j_back),
    .blocked_nx(j_blocked_nx)
  );

  always_comb begin
    ph_d = ph_q;
    slew_d = 1'b0;
    conf_clear = 1'b0;
    conf_trial = 1'b0;
    j_eval = 1'b0;
    j_arm = (ph_q != PH_TRACK);
    case (ph_q)
      PH_START: ph_d = PH_SEARCH;
      PH_SEARCH: begin
        if (meas_valid) begin
          if (above_acq) begin
            ph_d = PH_CONFIRM;
            conf_clear = 1'b1;
          end else begin
            slew_d = 1'b1;
          end
        end
      end
      PH_CONFIRM: begin
        if (meas_valid) begin
          conf_trial = 1'b1;
          if (conf_pass) ph_d = PH_PULL;
          else if (conf_fail) ph_d = PH_SEARCH;
        end
      end
      PH_PULL: begin
        if (meas_valid && pull_ok) ph_d = PH_TRACK;
      end
      PH_TRACK: begin
        if (meas_valid) begin
          if (below_acq) ph_d = PH_SEARCH;
          else j_eval = 1'b1;
        end
      end
      default: ph_d = PH_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_START;
      slew_req <= 1'b0;
      fstep_req <= 1'b0;
      loop_mode <= LOOP_OFF;
      jump_req <= 1'b0;
      jump_back <= 1'b0;
      state_num <= CODE_START;
    end else begin
      ph_q <= ph_d;
      slew_req <= slew_d;
      fstep_req <= slew_d;
      loop_mode <= loop_sel(ph_d);
      jump_req <= j_fire;
      if (j_fire) jump_back <= j_back;
      state_num <= phase_code(ph_d, j_blocked_nx);
    end
  end

endmodule

// File: rtl/trk_seq_chk.sv
module trk_seq_chk #(
  parameter int PW_W = 16,
  parameter int ER_W = 16,
  parameter int BJ_W = 16,
  parameter int CNT_W = 6,
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              meas_valid,
  input logic [PW_W-1:0]   pwr,
  input logic [PW_W-1:0]   avg_pwr,
  input logic [ER_W-1:0]   avg_perr,
  input logic [BJ_W-1:0]   bj_metric,
  input logic [PW_W-1:0]   thr_acq,
  input logic [PW_W-1:0]   thr_trk,
  input logic [ER_W-1:0]   lim_perr,
  input logic [BJ_W-1:0]   thr_bj,
  input logic              slew_req,
  input logic [1:0]        loop_mode,
  input logic              jump_req,
  input logic              jump_back,
  input logic [3:0]        state_num
);
  logic [BJ_W-1:0] abs_m;
  assign abs_m = bj_metric[BJ_W-1] ? (~bj_metric + {{(BJ_W-1){1'b0}}, 1'b1}) : bj_metric;

  AST_START_TO_SEARCH: assert property (@(posedge clk) disable iff (rst)
    state_num == 4'd0 |=> state_num == 4'd1); // R1

  AST_SLEW_IN_SEARCH: assert property (@(posedge clk) disable iff (rst)
    slew_req |-> (state_num == 4'd1) && $past(state_num) == 4'd1); // R2

  AST_CONFIRM_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_num == 4'd3 && $past(state_num) == 4'd1) |-> $past(meas_valid && (pwr > thr_acq))); // R2

  AST_PULL_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_num == 4'd9 && $past(state_num) == 4'd8)
      |-> $past(meas_valid && (avg_pwr > thr_trk) && (avg_perr < lim_perr))); // R4

  AST_TRACK_MODE: assert property (@(posedge clk) disable iff (rst)
    loop_mode == 2'd2 |-> (state_num == 4'd9 || state_num == 4'd10)); // R5

  AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (rst)
    (state_num == 4'd1 && ($past(state_num) == 4'd9 || $past(state_num) == 4'd10))
      |-> $past(pwr < thr_acq)); // R6

  AST_JUMP_MAG: assert property (@(posedge clk) disable iff (rst)
    jump_req |-> $past(meas_valid) && ($past(abs_m) > $past(thr_bj))
      && (jump_back == $past(bj_metric[BJ_W-1]))); // R7

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({jump_req, slew_req})); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(meas_valid) && $past(state_num) != 4'd0 && !$past(rst)) |-> $stable(state_num)); // R9

endmodule

bind trk_seq_ctrl trk_seq_chk #(
  .PW_W(PW_W), .ER_W(ER_W), .BJ_W(BJ_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)
) chk_i (
  .clk(clk), .rst(rst), .meas_valid(meas_valid), .pwr(pwr), .avg_pwr(avg_pwr),
  .avg_perr(avg_perr), .bj_metric(bj_metric), .thr_acq(thr_acq), .thr_trk(thr_trk),
  .lim_perr(lim_perr), .thr_bj(thr_bj), .slew_req(slew_req), .loop_mode(loop_mode),
  .jump_req(jump_req), .jump_back(jump_back), .state_num(state_num)
);

// File: tb/trk_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module trk_seq_ctrl_tb_top;
  localparam int PW_W = 8;
  localparam int ER_W = 8;
  localparam int BJ_W = 8;
  localparam int CNT_W = 4;
  localparam int HOLD_W = 4;

  typedef struct packed {
    logic [7:0] pwr;
    logic [7:0] apwr;
    logic [7:0] perr;
    logic [7:0] bj;
    logic [3:0] st;
    logic       slew;
    logic       jmp;
    logic       back;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{8'd10, 8'd0, 8'd0, 8'd0,   4'd1,  1'b1, 1'b0, 1'b0, 4'd2},  // R2 weak power slews
    '{8'd50, 8'd0, 8'd0, 8'd0,   4'd1,  1'b1, 1'b0, 1'b0, 4'd2},  // R2 equal is not above
    '{8'd60, 8'd0, 8'd0, 8'd0,   4'd3,  1'b0, 1'b0, 1'b0, 4'd2},  // R2 to confirm
    '{8'd10, 8'd0, 8'd0, 8'd0,   4'd3,  1'b0, 1'b0, 1'b0, 4'd3},  // R3 trial 1 miss
    '{8'd10, 8'd0, 8'd0, 8'd0,   4'd3,  1'b0, 1'b0, 1'b0, 4'd3},
    '{8'd10, 8'd0, 8'd0, 8'd0,   4'd3,  1'b0, 1'b0, 1'b0, 4'd3},
    '{8'd10, 8'd0, 8'd0, 8'd0,   4'd1,  1'b0, 1'b0, 1'b0, 4'd3},  // R3 N trials fail
    '{8'd70, 8'd0, 8'd0, 8'd0,   4'd3,  1'b0, 1'b0, 1'b0, 4'd2},
    '{8'd70, 8'd0, 8'd0, 8'd0,   4'd3,  1'b0, 1'b0, 1'b0, 4'd3},  // R3 hit 1
    '{8'd10, 8'd0, 8'd0, 8'd0,   4'd3,  1'b0, 1'b0, 1'b0, 4'd3},
    '{8'd90, 8'd0, 8'd0, 8'd0,   4'd8,  1'b0, 1'b0, 1'b0, 4'd3},  // R3 hit 2 pass
    '{8'd0, 8'd100, 8'd5, 8'd0,  4'd8,  1'b0, 1'b0, 1'b0, 4'd4},  // R4 power equal
    '{8'd0, 8'd120, 8'd20, 8'd0, 4'd8,  1'b0, 1'b0, 1'b0, 4'd4},  // R4 error equal
    '{8'd0, 8'd120, 8'd19, 8'd0, 4'd9,  1'b0, 1'b0, 1'b0, 4'd4},  // R4 exit
    '{8'd80, 8'd0, 8'd0, 8'd40,  4'd9,  1'b0, 1'b0, 1'b0, 4'd7},  // R7 equal magnitude
    '{8'd80, 8'd0, 8'd0, 8'hD8,  4'd9,  1'b0, 1'b0, 1'b0, 4'd7},  // R7 -40
    '{8'd50, 8'd0, 8'd0, 8'd0,   4'd9,  1'b0, 1'b0, 1'b0, 4'd6},  // R6 equal keeps lock
    '{8'd80, 8'd0, 8'd0, 8'd41,  4'd10, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 forward jump
    '{8'd80, 8'd0, 8'd0, 8'd100, 4'd10, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 blocked
    '{8'd80, 8'd0, 8'd0, 8'd100, 4'd9,  1'b0, 1'b0, 1'b0, 4'd8},  // R8 last blocked
    '{8'd80, 8'd0, 8'd0, 8'h80,  4'd10, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 -128 back jump
    '{8'd30, 8'd0, 8'd0, 8'd100, 4'd1,  1'b0, 1'b0, 1'b0, 4'd6},  // R6 loss beats jump
    '{8'd30, 8'd0, 8'd0, 8'd0,   4'd1,  1'b1, 1'b0, 1'b0, 4'd2}   // R2 search again
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic meas_valid = 1'b0;
  logic [PW_W-1:0] pwr = '0, avg_pwr = '0;
  logic [ER_W-1:0] avg_perr = '0;
  logic [BJ_W-1:0] bj_metric = '0;
  logic [PW_W-1:0] thr_acq = 8'd50, thr_trk = 8'd100;
  logic [ER_W-1:0] lim_perr = 8'd20;
  logic [BJ_W-1:0] thr_bj = 8'd40;
  logic [CNT_W-1:0] m_hits = 4'd2, n_trials = 4'd4;
  logic [HOLD_W-1:0] holdoff_len = 4'd2;
  logic slew_req, fstep_req, jump_req, jump_back;
  logic [1:0] loop_mode;
  logic [3:0] state_num;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trk_seq_ctrl #(.PW_W(PW_W), .ER_W(ER_W), .BJ_W(BJ_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)) dut_i (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .pwr(pwr), .avg_pwr(avg_pwr),
    .avg_perr(avg_perr), .bj_metric(bj_metric), .thr_acq(thr_acq), .thr_trk(thr_trk),
    .lim_perr(lim_perr), .thr_bj(thr_bj), .m_hits(m_hits), .n_trials(n_trials),
    .holdoff_len(holdoff_len), .slew_req(slew_req), .fstep_req(fstep_req),
    .loop_mode(loop_mode), .jump_req(jump_req), .jump_back(jump_back), .state_num(state_num)
  );

  task automatic chk(input int req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mode_of(input int st);
    if (st == 8) return 1;
    if (st == 9 || st == 10) return 2;
    return 0;
  endfunction

  task automatic period(input logic [7:0] p, ap, pe, bj);
    @(negedge clk);
    pwr = p; avg_pwr = ap; avg_perr = pe; bj_metric = bj;
    meas_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #50000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(1, "reset state", state_num, 0);
    chk(1, "reset mode", loop_mode, 0);
    chk(1, "reset pulses", {slew_req, fstep_req, jump_req}, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(1, "start to search", state_num, 1);

    for (int i = 0; i < NV; i++) begin
      period(VECS[i].pwr, VECS[i].apwr, VECS[i].perr, VECS[i].bj);
      chk(VECS[i].req, $sformatf("row %0d state", i), state_num, VECS[i].st);
      chk(VECS[i].req, $sformatf("row %0d slew", i), slew_req, VECS[i].slew);
      chk(VECS[i].req, $sformatf("row %0d fstep", i), fstep_req, VECS[i].slew);
      chk(VECS[i].req, $sformatf("row %0d jump", i), jump_req, VECS[i].jmp);
      if (VECS[i].jmp) chk(VECS[i].req, $sformatf("row %0d dir", i), jump_back, VECS[i].back);
      chk(5, $sformatf("row %0d loop mode", i), loop_mode, mode_of(VECS[i].st)); // R5
    end

    // R9 no strobe: strong power must not move search or pulse
    @(negedge clk);
    pwr = 8'd200;
    repeat (3) begin
      @(negedge clk);
      chk(9, "idle state", state_num, 1);
      chk(9, "idle slew", slew_req, 0);
    end

    // R3 M-th hit on the N-th trial passes
    n_trials = 4'd2;
    period(8'd60, 8'd0, 8'd0, 8'd0);
    chk(3, "enter confirm", state_num, 3);
    period(8'd60, 8'd0, 8'd0, 8'd0);
    chk(3, "one hit", state_num, 3);
    period(8'd60, 8'd0, 8'd0, 8'd0);
    chk(3, "pass beats fail", state_num, 8);
    chk(5, "pull mode", loop_mode, 1);

    // R1 reset from pull-in
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(1, "mid reset state", state_num, 0);
    chk(1, "mid reset mode", loop_mode, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(1, "restart search", state_num, 1);

    finish_run();
  end

endmodule